// File: doc/BRIEF.md
# Dual-Mode Microprocessor Register Port

This block lets an external 8-bit microprocessor read and write a bank of internal registers over one of two bus styles. A strap input picks the style. In multiplexed mode, address and data share the first byte-wide bus, and an address latch strobe captures the address. In separate mode, the first bus carries only the address and the second bus carries the data. Two chip-select inputs must both be high before the block accepts an access. The read and write strobes are active low, and each bus has a tri-state enable so that pads outside the block can drive it.

Internal logic, which sits outside this block, updates registers through a dedicated write port. Four watched locations each keep a pending bit when internal logic updates them. An active-low change flag tells the processor that at least one watched location holds news. Reading a watched location clears its pending bit. All bus strobes are asynchronous. Each one passes through a two-stage synchronizer into the system clock, and edge detection then turns it into a one-cycle event.

Top module: `dual_bus_regif`

## Requirements
- R1: With `muxMode` at 1, the value on `busAIn` is captured as the address when `aleIn` falls. `busBOe` stays 1, and `busBOut` shows the captured address at all times. Read data appears on `busAOut`.
- R2: With `muxMode` at 0, `busAIn` is the address input and is never driven, so `busAOe` is 0. `busBIn` and `busBOut` carry the data.
- R3: An access is accepted only while both `csA` and `csB` are 1. A write with either one low leaves the registers unchanged. A read with either one low does not drive the data bus.
- R4: A CPU write stores the data-bus value into the addressed register when `wrN` rises. A later read of that address returns the value.
- R5: The data-bus enable is 1 only while the chip is selected and `rdN` is 0. At all other times the data bus is high-impedance.
- R6: The bank holds 32 byte registers at addresses 0x00 to 0x1F. Addresses 0x20 and above read as 0x00, and writes to them change no register.
- R7: An internal update to address 0x0C, 0x0D, 0x1E or 0x1F drives `chgN` low in the next cycle, and the updated value can be read back. Internal updates to other addresses, and CPU writes, leave `chgN` unchanged.
- R8: Each watched address has its own pending bit, which a CPU read of that address clears. Reading a different address leaves the bit set. `chgN` returns to 1 once every pending bit is clear.
- R9: If an internal update to a watched address coincides with the read that would clear it, the pending bit stays set and `chgN` stays 0.
- R10: After reset, every register reads 0x00, `chgN` is 1, and no bus is driven in separate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| muxMode | input | 1 | Bus style strap: 1 selects multiplexed, 0 selects separate |
| csA | input | 1 | Chip select, active high |
| csB | input | 1 | Second chip select, active high |
| aleIn | input | 1 | Address latch strobe; the address is captured on its falling edge |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low; the write commits on its rising edge |
| busAIn | input | 8 | First bus, input side |
| busAOut | output | 8 | First bus, output side (read data in multiplexed mode) |
| busAOe | output | 1 | First bus drive enable |
| busBIn | input | 8 | Second bus, input side (write data in separate mode) |
| busBOut | output | 8 | Second bus, output side (latched address or read data) |
| busBOe | output | 1 | Second bus drive enable |
| intWrEn | input | 1 | Internal update strobe |
| intWrAddr | input | 5 | Internal update address |
| intWrData | input | 8 | Internal update data |
| chgN | output | 1 | Change flag, low while any watched register is pending |

## Verification
Assertions check four things on every clock cycle. The bus enables never drive the data path outside a selected read, the address bus is never driven in separate mode, and an internal update of a watched register always pulls the change flag low. A write to an address outside the bank also leaves every register stable. The bench scenarios cover what the assertions cannot. They confirm round-trip data through both bus styles, the address echo, and that deselected writes are ignored. They also show per-register clearing of the flag, and that a coincident update and read keeps the flag low.

// File: rtl/dual_bus_pkg.sv
package dual_bus_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int NUM_WATCH = 4;

  // Addresses whose internal updates raise the change flag
  localparam logic [7:0] WATCH_ADDR [NUM_WATCH] = '{8'h0C, 8'h0D, 8'h1E, 8'h1F};

  // One-cycle events from the control side to the datapath
  typedef struct packed {
    logic latchAddr;
    logic commitWrite;
    logic readAck;
  } busStrobes_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {(STAGES + 1){IDLE}};
    else       chain <= {chain[STAGES-1:0], asyncIn};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import dual_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        muxMode,
  input  logic        csA,
  input  logic        csB,
  input  logic        aleIn,
  input  logic        rdN,
  input  logic        wrN,
  output logic        selected,
  output busStrobes_t strobes
);
  logic aleRise, aleFall;
  logic rdRise, rdFall;
  logic wrRise, wrFall;

  strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) uAle (
    .clk(clk), .rstN(rstN), .asyncIn(aleIn), .rise(aleRise), .fall(aleFall));
  strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) uRd (
    .clk(clk), .rstN(rstN), .asyncIn(rdN), .rise(rdRise), .fall(rdFall));
  strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) uWr (
    .clk(clk), .rstN(rstN), .asyncIn(wrN), .rise(wrRise), .fall(wrFall));

  assign selected = csA & csB;

  always_comb begin
    strobes             = '0;
    strobes.latchAddr   = muxMode & aleFall;
    strobes.commitWrite = selected & wrRise;
    strobes.readAck     = selected & rdRise;
  end

  // Edge outputs not used as events
  logic unusedEdges;
  assign unusedEdges = aleRise ^ rdFall ^ wrFall;
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import dual_bus_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int AW       = ADDR_W,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             muxMode,
  input  logic             selected,
  input  logic             rdN,
  input  busStrobes_t      strobes,
  input  logic [AW-1:0]    busAIn,
  input  logic [DW-1:0]    busBIn,
  input  logic             intWrEn,
  input  logic [IDX_W-1:0] intWrAddr,
  input  logic [DW-1:0]    intWrData,
  output logic [AW-1:0]    busAOut,
  output logic             busAOe,
  output logic [DW-1:0]    busBOut,
  output logic             busBOe,
  output logic             chgN
);
  logic [AW-1:0] latchedAddr;
  logic [AW-1:0] cpuAddr;
  logic [DW-1:0] cpuWrData;
  logic [DW-1:0] readData;
  logic          inRange;
  logic          dataOe;
  logic [DW-1:0] regFile [NUM_REGS];
  logic [NUM_WATCH-1:0] pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  latchedAddr <= '0;
    else if (strobes.latchAddr) latchedAddr <= busAIn;
  end

  assign cpuAddr   = muxMode ? latchedAddr : busAIn;
  assign cpuWrData = muxMode ? DW'(busAIn) : busBIn;
  assign inRange   = cpuAddr < AW'(NUM_REGS);

  for (genvar k = 0; k < NUM_REGS; k++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[k] <= '0;
      else if (intWrEn && intWrAddr == IDX_W'(k))
        regFile[k] <= intWrData;
      else if (strobes.commitWrite && cpuAddr == AW'(k))
        regFile[k] <= cpuWrData;
    end

    assert_range_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.commitWrite && !inRange && !intWrEn) |=> $stable(regFile[k]));
  end

  assign readData = inRange ? regFile[cpuAddr[IDX_W-1:0]] : '0;

  for (genvar w = 0; w < NUM_WATCH; w++) begin : gWatch
    localparam logic [7:0] WA = WATCH_ADDR[w];
    logic setEv, clrEv;
    assign setEv = intWrEn && intWrAddr == WA[IDX_W-1:0];
    assign clrEv = strobes.readAck && cpuAddr == AW'(WA);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      pend[w] <= 1'b0;
      else if (setEv) pend[w] <= 1'b1;
      else if (clrEv) pend[w] <= 1'b0;
    end

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
      setEv |=> !chgN);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      (clrEv && !setEv && pend[w] && $countones(pend) == 1) |=> chgN);
  end

  assign chgN = ~|pend;

  assign dataOe  = selected & ~rdN;
  assign busAOe  = muxMode & dataOe;
  assign busAOut = AW'(readData);
  assign busBOe  = muxMode | dataOe;
  assign busBOut = muxMode ? DW'(latchedAddr) : readData;

  assert_no_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAOe || (busBOe && !muxMode)) |-> (selected && !rdN));
  assert_sep_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    !muxMode |-> !busAOe);
endmodule

// File: rtl/dual_bus_regif.sv
module dual_bus_regif
  import dual_bus_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int AW          = ADDR_W,
  parameter int NUM_REGS    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             muxMode,
  input  logic             csA,
  input  logic             csB,
  input  logic             aleIn,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [AW-1:0]    busAIn,
  output logic [AW-1:0]    busAOut,
  output logic             busAOe,
  input  logic [DW-1:0]    busBIn,
  output logic [DW-1:0]    busBOut,
  output logic             busBOe,
  input  logic             intWrEn,
  input  logic [IDX_W-1:0] intWrAddr,
  input  logic [DW-1:0]    intWrData,
  output logic             chgN
);
  busStrobes_t strobes;
  logic        selected;

  bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .csA(csA), .csB(csB),
    .aleIn(aleIn), .rdN(rdN), .wrN(wrN), .selected(selected), .strobes(strobes));

  bus_datapath #(.DW(DW), .AW(AW), .NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .selected(selected), .rdN(rdN),
    .strobes(strobes), .busAIn(busAIn), .busBIn(busBIn), .intWrEn(intWrEn),
    .intWrAddr(intWrAddr), .intWrData(intWrData), .busAOut(busAOut),
    .busAOe(busAOe), .busBOut(busBOut), .busBOe(busBOe), .chgN(chgN));
endmodule

// File: tb/tb_dual_bus_regif.sv
module tb_dual_bus_regif;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       muxMode = 1'b0, csA = 1'b0, csB = 1'b0;
  logic       aleIn = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] busAIn = '0, busBIn = '0;
  logic [7:0] busAOut, busBOut;
  logic       busAOe, busBOe, chgN;
  logic       intWrEn = 1'b0;
  logic [4:0] intWrAddr = '0;
  logic [7:0] intWrData = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dual_bus_regif dut (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .csA(csA), .csB(csB),
    .aleIn(aleIn), .rdN(rdN), .wrN(wrN), .busAIn(busAIn), .busAOut(busAOut),
    .busAOe(busAOe), .busBIn(busBIn), .busBOut(busBOut), .busBOe(busBOe),
    .intWrEn(intWrEn), .intWrAddr(intWrAddr), .intWrData(intWrData), .chgN(chgN));

  // {mode, address, data}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h00, 8'hA5}, {1'b0, 8'h01, 8'h5A}, {1'b1, 8'h1F, 8'h3C},
    {1'b0, 8'h10, 8'hFF}, {1'b1, 8'h20, 8'h77}, {1'b0, 8'hFF, 8'h12},
    {1'b1, 8'h0C, 8'h81}, {1'b0, 8'h07, 8'h00}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAddr(input bit mode, input logic [7:0] addr);
    muxMode = mode;
    busAIn  = addr;
    if (mode) begin
      aleIn = 1'b1; waitCyc(4);
      aleIn = 1'b0; waitCyc(5);
    end
  endtask

  task automatic cpuWrite(input bit mode, input logic [7:0] addr,
                          input logic [7:0] data, input bit selA);
    @(negedge clk);
    csA = selA; csB = 1'b1;
    setAddr(mode, addr);
    if (mode) busAIn = data; else busBIn = data;
    wrN = 1'b0; waitCyc(4);
    wrN = 1'b1; waitCyc(6);
    csA = 1'b0; csB = 1'b0;
  endtask

  task automatic cpuRead(input bit mode, input logic [7:0] addr, input bit selA,
                         output logic [7:0] val, output logic oe);
    @(negedge clk);
    csA = selA; csB = 1'b1;
    setAddr(mode, addr);
    rdN = 1'b0; waitCyc(4);
    val = mode ? busAOut : busBOut;
    oe  = mode ? busAOe : busBOe;
    rdN = 1'b1; waitCyc(6);
    csA = 1'b0; csB = 1'b0;
  endtask

  task automatic intWrite(input logic [4:0] addr, input logic [7:0] data);
    @(negedge clk);
    intWrEn = 1'b1; intWrAddr = addr; intWrData = data;
    @(negedge clk);
    intWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic oe;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R10: reset state
    chk("R10 chgN", {7'd0, chgN}, 8'h01);
    chk("R10 busAOe", {7'd0, busAOe}, 8'h00);
    chk("R10 busBOe", {7'd0, busBOe}, 8'h00);
    cpuRead(1'b0, 8'h05, 1'b1, v, oe);
    chk("R10 reg zero", v, 8'h00);

    // R4 R6 R1 R2: vector walk, write then read back in both bus styles
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp;
      exp = (VEC[i][15:8] < 8'h20) ? VEC[i][7:0] : 8'h00;
      cpuWrite(VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b1);
      cpuRead(VEC[i][16], VEC[i][15:8], 1'b1, v, oe);
      chk("R4 R6 readback same mode", v, exp);
      chk("R5 oe during read", {7'd0, oe}, 8'h01);
      cpuRead(~VEC[i][16], VEC[i][15:8], 1'b1, v, oe);
      chk("R1 R2 readback other mode", v, exp);
    end
    // R6: high address writes must not alias into the bank
    cpuRead(1'b0, 8'h00, 1'b1, v, oe);
    chk("R6 no alias 0x20", v, 8'hA5);
    cpuRead(1'b0, 8'h1F, 1'b1, v, oe);
    chk("R6 no alias 0xFF", v, 8'h3C);
    // R7: CPU writes to watched register leave flag high
    chk("R7 cpu write no flag", {7'd0, chgN}, 8'h01);

    // R1: address echo on second bus
    @(negedge clk);
    setAddr(1'b1, 8'h2B);
    chk("R1 echo oe", {7'd0, busBOe}, 8'h01);
    chk("R1 echo addr", busBOut, 8'h2B);

    // R2 R5: separate mode, selected but no read strobe
    @(negedge clk);
    muxMode = 1'b0; csA = 1'b1; csB = 1'b1; rdN = 1'b1;
    waitCyc(1);
    chk("R5 idle busBOe", {7'd0, busBOe}, 8'h00);
    rdN = 1'b0; waitCyc(1);
    chk("R2 busAOe during read", {7'd0, busAOe}, 8'h00);
    rdN = 1'b1; waitCyc(6);
    csA = 1'b0; csB = 1'b0;

    // R3: deselected write ignored, deselected read not driven
    cpuWrite(1'b0, 8'h01, 8'hEE, 1'b0);
    cpuWrite(1'b1, 8'h01, 8'hDD, 1'b0);
    cpuRead(1'b0, 8'h01, 1'b1, v, oe);
    chk("R3 deselected write ignored", v, 8'h5A);
    cpuRead(1'b1, 8'h01, 1'b0, v, oe);
    chk("R3 deselected read no drive", {7'd0, oe}, 8'h00);

    // R7: non-watched internal update keeps flag high
    intWrite(5'h0B, 8'h44);
    waitCyc(1);
    chk("R7 non-watched", {7'd0, chgN}, 8'h01);
    cpuRead(1'b0, 8'h0B, 1'b1, v, oe);
    chk("R7 internal data", v, 8'h44);

    // R7 R8: watched update, read of other address keeps, own read clears
    intWrite(5'h0D, 8'h62);
    waitCyc(1);
    chk("R7 watched sets flag", {7'd0, chgN}, 8'h00);
    cpuRead(1'b1, 8'h0C, 1'b1, v, oe);
    chk("R8 other read keeps flag", {7'd0, chgN}, 8'h00);
    cpuRead(1'b1, 8'h0D, 1'b1, v, oe);
    chk("R7 watched data", v, 8'h62);
    chk("R8 own read clears flag", {7'd0, chgN}, 8'h01);

    // R8: two pending bits need two reads
    intWrite(5'h0C, 8'h11);
    intWrite(5'h1F, 8'h22);
    cpuRead(1'b0, 8'h1F, 1'b1, v, oe);
    chk("R8 one of two cleared", {7'd0, chgN}, 8'h00);
    cpuRead(1'b0, 8'h0C, 1'b1, v, oe);
    chk("R8 both cleared", {7'd0, chgN}, 8'h01);

    // R9: update held across the whole read keeps the bit set
    @(negedge clk);
    intWrEn = 1'b1; intWrAddr = 5'h1E; intWrData = 8'h99;
    cpuRead(1'b0, 8'h1E, 1'b1, v, oe);
    intWrEn = 1'b0;
    waitCyc(2);
    chk("R9 coincident keeps flag", {7'd0, chgN}, 8'h00);
    cpuRead(1'b0, 8'h1E, 1'b1, v, oe);
    chk("R9 data", v, 8'h99);
    chk("R8 later read clears", {7'd0, chgN}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule